// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds the eight 64-bit registers of a floating-point register stack. Callers reach a register by its position below the top of the stack, not by its physical slot. A 3-bit top pointer inside a 16-bit status word picks which physical slot is the current top. Each physical slot has a 2-bit tag that says whether it holds a value or is empty. The payload is stored as an opaque 64-bit word. No arithmetic, rounding or memory transfer takes place here.

The block accepts one command per clock cycle, together with a logical index and write data. The commands are read, push, pop, pointer increment, pointer decrement, free, initialise, and a combined write-then-pop. State and read data change at the clock edge after the command. An overflow or underflow does not stop the command. Instead it sets sticky fault bits in the status word, and a read or pop of an empty entry returns a negative quiet NaN. The status word, the control word and the tag word are always visible on output ports.

Top module: `fpstk_ctrl`

## Requirements
- R1: Reset and the INIT command (code 7) both give status 0x0000 and tag word 0xFFFF. Neither changes the control word, which is always 0x037F.
- R2: Logical index i maps to physical slot (i + top) mod 8. The top field is status bits 13:11. Slot p owns tag bits 2p+1:2p, with valid = 00 and empty = 11.
- R3: PUSH (code 2) moves top down by one, mod 8. It writes the data into the new top slot and marks that slot valid.
- R4: If the slot at logical index -1 is not empty, PUSH sets invalid (bit 0), stack fault (bit 6) and C1 (bit 9). The push still completes.
- R5: POP (code 3) of a valid top returns that value on the read data and marks the slot empty. Top then moves up by one, mod 8.
- R6: POP of an empty top sets invalid and stack fault and clears C1. It returns 0xFFF8000000000000 and still moves top up by one.
- R7: READ (code 1) of a valid entry returns its value and leaves the status unchanged. READ of an empty entry returns 0xFFF8000000000000, sets invalid and stack fault, and clears C1.
- R8: INC (code 4) and DEC (code 5) change only the top field, mod 8. The tag word is unchanged.
- R9: FREE (code 6) marks the addressed logical entry empty and leaves top unchanged.
- R10: WRPOP (code 8) first writes the data at the addressed logical index and marks it valid, then pops. The read data is the top value after that write. When the index is 0, the written value is popped straight back and the slot ends empty.
- R11: NOP (code 0) and the unused codes 9 to 15 leave status, tags and read data unchanged.
- R12: Fault bits stay set until INIT or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code |
| idx_i | input | 3 | Logical index relative to the top |
| wdata_i | input | 64 | Data for PUSH and WRPOP |
| rdata_o | output | 64 | Registered read or pop result |
| status_o | output | 16 | Status word: top field and fault bits |
| control_o | output | 16 | Control word |
| tags_o | output | 16 | Tag word, 2 bits per physical slot |

## Verification
The assertions assume that cmd_i and idx_i are known values in every cycle after reset and are held steady across each rising edge. They also assume that idx_i matters only for READ, FREE and WRPOP. The bench changes its inputs only on falling edges and starts driving only after reset has been released. It uses every defined code and one unused code, so each assertion that checks a transition sees inputs that are stable and fully defined.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int DEPTH = 8;
  localparam int PW    = $clog2(DEPTH);
  localparam int DW    = 64;
  localparam int TW    = 2 * DEPTH;
  localparam int SW    = 16;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_READ  = 4'd1,
    CMD_PUSH  = 4'd2,
    CMD_POP   = 4'd3,
    CMD_INC   = 4'd4,
    CMD_DEC   = 4'd5,
    CMD_FREE  = 4'd6,
    CMD_INIT  = 4'd7,
    CMD_WRPOP = 4'd8
  } cmd_e;

  localparam logic [1:0]    TAG_VALID = 2'b00;
  localparam logic [1:0]    TAG_EMPTY = 2'b11;
  localparam int            SB_IE     = 0;
  localparam int            SB_SF     = 6;
  localparam int            SB_C1     = 9;
  localparam int            SB_TOP    = 11;
  localparam logic [SW-1:0] CW_INIT   = 16'h037F;
  localparam logic [DW-1:0] NAN_NEG   = 64'hFFF8_0000_0000_0000;

  function automatic logic [1:0] tag_of(input logic [TW-1:0] t, input logic [PW-1:0] p);
    return t[2*p +: 2];
  endfunction
endpackage

// File: rtl/fpstk_regs.sv
module fpstk_regs #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_a_i,
  output logic [DW-1:0] rd_data_a_o,
  input  logic [AW-1:0] rd_addr_b_i,
  output logic [DW-1:0] rd_data_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en_i && (wr_addr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= '0;
      else if (slot_en) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_a_o = mem_q[rd_addr_a_i];
  assign rd_data_b_o = mem_q[rd_addr_b_i];
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int TW   = 2 * DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          set_en_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          clr_en_i,
  input  logic [AW-1:0] clr_addr_i,
  output logic [TW-1:0] tags_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    logic [1:0] tag_d, tag_q;
    logic       hit_set, hit_clr;
    assign hit_set = set_en_i && (set_addr_i == AW'(g));
    assign hit_clr = clr_en_i && (clr_addr_i == AW'(g));

    // clear is applied after set so a write-then-pop of one slot ends empty
    always_comb begin
      tag_d = tag_q;
      if (hit_set) tag_d = fpstk_pkg::TAG_VALID;
      if (hit_clr) tag_d = fpstk_pkg::TAG_EMPTY;
      if (init_i)  tag_d = fpstk_pkg::TAG_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q <= fpstk_pkg::TAG_EMPTY;
      else        tag_q <= tag_d;
    end

    assign tags_o[2*g +: 2] = tag_q;
  end
endmodule

// File: rtl/fpstk_stat.sv
module fpstk_stat
  import fpstk_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cmd_i,
  input  logic             idx_zero_i,
  input  logic             idx_empty_i,
  input  logic             top_empty_i,
  input  logic             below_empty_i,
  output logic [SW-1:0]    status_o,
  output logic [PTR_W-1:0] top_o
);
  logic [SW-1:0]    st_d, st_q;
  logic [PTR_W-1:0] top_d;
  logic             ovf, unf;

  assign top_o = st_q[SB_TOP +: PTR_W];

  always_comb begin
    st_d  = st_q;
    top_d = top_o;
    ovf   = 1'b0;
    unf   = 1'b0;
    case (cmd_i)
      CMD_PUSH: begin
        top_d = top_o - PTR_W'(1);
        ovf   = !below_empty_i;
      end
      CMD_POP: begin
        top_d = top_o + PTR_W'(1);
        unf   = top_empty_i;
      end
      CMD_WRPOP: begin
        top_d = top_o + PTR_W'(1);
        unf   = top_empty_i && !idx_zero_i;
      end
      CMD_READ: unf   = idx_empty_i;
      CMD_INC:  top_d = top_o + PTR_W'(1);
      CMD_DEC:  top_d = top_o - PTR_W'(1);
      default: ;
    endcase
    st_d[SB_TOP +: PTR_W] = top_d;
    if (ovf) begin
      st_d[SB_IE] = 1'b1;
      st_d[SB_SF] = 1'b1;
      st_d[SB_C1] = 1'b1;
    end
    if (unf) begin
      st_d[SB_IE] = 1'b1;
      st_d[SB_SF] = 1'b1;
      st_d[SB_C1] = 1'b0;
    end
    if (cmd_i == CMD_INIT) st_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;

  AST_PUSH_TOP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_PUSH |=> top_o == PTR_W'($past(top_o) - PTR_W'(1))); // R3
  AST_PUSH_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PUSH && !below_empty_i) |=> (status_o[SB_IE] && status_o[SB_SF] && status_o[SB_C1])); // R4
  AST_POP_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_POP && top_empty_i) |=> (status_o[SB_IE] && status_o[SB_SF] && !status_o[SB_C1])); // R6
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_INIT |=> status_o == '0); // R1
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[SB_IE] && cmd_i != CMD_INIT) |=> status_o[SB_IE]); // R12
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cmd_i,
  input  logic [PW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [SW-1:0] status_o,
  output logic [SW-1:0] control_o,
  output logic [TW-1:0] tags_o
);
  logic [PW-1:0] top, phys_idx, phys_below;
  logic          idx_empty, top_empty, below_empty, idx_zero;
  logic [DW-1:0] val_idx, val_top;
  logic          wr_en, set_en, clr_en, is_init;
  logic [PW-1:0] wr_addr, clr_addr;
  logic [DW-1:0] rd_d, rd_q;
  logic          rd_en;

  assign phys_idx    = idx_i + top;
  assign phys_below  = top - PW'(1);
  assign idx_zero    = (idx_i == '0);
  assign idx_empty   = (tag_of(tags_o, phys_idx)   == TAG_EMPTY);
  assign top_empty   = (tag_of(tags_o, top)        == TAG_EMPTY);
  assign below_empty = (tag_of(tags_o, phys_below) == TAG_EMPTY);

  assign is_init  = (cmd_i == CMD_INIT);
  assign wr_en    = (cmd_i == CMD_PUSH) || (cmd_i == CMD_WRPOP);
  assign wr_addr  = (cmd_i == CMD_PUSH) ? phys_below : phys_idx;
  assign set_en   = wr_en;
  assign clr_en   = (cmd_i == CMD_POP) || (cmd_i == CMD_WRPOP) || (cmd_i == CMD_FREE);
  assign clr_addr = (cmd_i == CMD_FREE) ? phys_idx : top;

  fpstk_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wdata_i),
    .rd_addr_a_i (phys_idx),
    .rd_data_a_o (val_idx),
    .rd_addr_b_i (top),
    .rd_data_b_o (val_top)
  );

  fpstk_tags #(.DEPTH(DEPTH)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (is_init),
    .set_en_i   (set_en),
    .set_addr_i (wr_addr),
    .clr_en_i   (clr_en),
    .clr_addr_i (clr_addr),
    .tags_o     (tags_o)
  );

  fpstk_stat #(.PTR_W(PW)) u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_i         (cmd_i),
    .idx_zero_i    (idx_zero),
    .idx_empty_i   (idx_empty),
    .top_empty_i   (top_empty),
    .below_empty_i (below_empty),
    .status_o      (status_o),
    .top_o         (top)
  );

  // registered result path
  always_comb begin
    rd_en = 1'b1;
    rd_d  = rd_q;
    case (cmd_i)
      CMD_READ:  rd_d = idx_empty ? NAN_NEG : val_idx;
      CMD_POP:   rd_d = top_empty ? NAN_NEG : val_top;
      CMD_WRPOP: rd_d = idx_zero ? wdata_i : (top_empty ? NAN_NEG : val_top);
      default:   rd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata_o   = rd_q;
  assign control_o = CW_INIT;

  AST_STEP_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_INC || cmd_i == CMD_DEC) |=> $stable(tags_o)); // R8
  AST_FREE_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_FREE |=> $stable(top)); // R9
  AST_PUSH_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_PUSH |=> tag_of(tags_o, top) == TAG_VALID); // R3
  AST_POP_MARKS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i == CMD_POP |=> tag_of(tags_o, top - PW'(1)) == TAG_EMPTY); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_NOP || cmd_i > CMD_WRPOP) |=> ($stable(status_o) && $stable(tags_o) && $stable(rdata_o))); // R11
endmodule

// File: tb/fpstk_ctrl_bench.sv
`timescale 1ns/1ps
module fpstk_ctrl_bench;
  import fpstk_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    cmd;
  logic [2:0]    idx;
  logic [63:0]   wd;
  logic [63:0]   rdata;
  logic [15:0]   status, control, tags;
  int            total = 0;
  int            bad = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  fpstk_ctrl u_fpstk_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .idx_i(idx), .wdata_i(wd),
    .rdata_o(rdata), .status_o(status), .control_o(control), .tags_o(tags)
  );

  typedef struct packed {
    logic [3:0]  c;
    logic [2:0]  i;
    logic [63:0] w;
    logic        chk;
    logic [63:0] rd;
    logic [15:0] st;
    logic [15:0] tg;
  } vec_t;

  localparam logic [63:0] QN = 64'hFFF8_0000_0000_0000;
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 3'd0, 64'h1111, 1'b0, 64'h0,    16'h3800, 16'h3FFF}, // R3 push into empty
    '{4'd2, 3'd0, 64'h2222, 1'b0, 64'h0,    16'h3000, 16'h0FFF}, // R3
    '{4'd1, 3'd1, 64'h0,    1'b1, 64'h1111, 16'h3000, 16'h0FFF}, // R2 R7 read depth 1
    '{4'd1, 3'd0, 64'h0,    1'b1, 64'h2222, 16'h3000, 16'h0FFF}, // R2 R7
    '{4'd4, 3'd0, 64'h0,    1'b0, 64'h0,    16'h3800, 16'h0FFF}, // R8 inc
    '{4'd5, 3'd0, 64'h0,    1'b0, 64'h0,    16'h3000, 16'h0FFF}, // R8 dec
    '{4'd3, 3'd0, 64'h0,    1'b1, 64'h2222, 16'h3800, 16'h3FFF}, // R5 pop valid
    '{4'd1, 3'd2, 64'h0,    1'b1, QN,       16'h3841, 16'h3FFF}, // R7 read empty
    '{4'd7, 3'd0, 64'h0,    1'b0, 64'h0,    16'h0000, 16'hFFFF}, // R1 R12 init
    '{4'd2, 3'd0, 64'h3333, 1'b0, 64'h0,    16'h3800, 16'h3FFF}, // R3
    '{4'd6, 3'd0, 64'h0,    1'b0, 64'h0,    16'h3800, 16'hFFFF}, // R9 free
    '{4'd3, 3'd0, 64'h0,    1'b1, QN,       16'h0041, 16'hFFFF}, // R6 pop empty
    '{4'd7, 3'd0, 64'h0,    1'b0, 64'h0,    16'h0000, 16'hFFFF}, // R1
    '{4'd5, 3'd0, 64'h0,    1'b0, 64'h0,    16'h3800, 16'hFFFF}, // R8 wrap down
    '{4'd4, 3'd0, 64'h0,    1'b0, 64'h0,    16'h0000, 16'hFFFF}, // R8 wrap up
    '{4'd2, 3'd0, 64'h4444, 1'b0, 64'h0,    16'h3800, 16'h3FFF}, // R3
    '{4'd2, 3'd0, 64'h5555, 1'b0, 64'h0,    16'h3000, 16'h0FFF}, // R3
    '{4'd8, 3'd1, 64'h6666, 1'b1, 64'h5555, 16'h3800, 16'h3FFF}, // R10 write below then pop
    '{4'd1, 3'd0, 64'h0,    1'b1, 64'h6666, 16'h3800, 16'h3FFF}, // R10 written value landed
    '{4'd8, 3'd0, 64'h7777, 1'b1, 64'h7777, 16'h0000, 16'hFFFF}, // R10 index 0
    '{4'd9, 3'd0, 64'hABCD, 1'b1, 64'h7777, 16'h0000, 16'hFFFF}, // R11 unused code
    '{4'd0, 3'd3, 64'hABCD, 1'b1, 64'h7777, 16'h0000, 16'hFFFF}  // R11 nop
  };

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [2:0] i, input logic [63:0] w);
    cmd = c; idx = i; wd = w;
    @(negedge clk);
    cmd = 4'd0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd = 4'd0; idx = 3'd0; wd = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", 64'(status), 64'h0);
    chk("R1 reset tags", 64'(tags), 64'hFFFF);
    chk("R1 control word", 64'(control), 64'h037F);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      step(VEC[n].c, VEC[n].i, VEC[n].w);
      if (VEC[n].chk) chk($sformatf("table row %0d rdata", n), rdata, VEC[n].rd);
      chk($sformatf("table row %0d status", n), 64'(status), 64'(VEC[n].st));
      chk($sformatf("table row %0d tags", n), 64'(tags), 64'(VEC[n].tg));
    end

    // R4: fill all eight slots, then one push too many
    step(4'd7, 3'd0, 64'h0);
    for (int k = 0; k < 8; k++) step(4'd2, 3'd0, 64'(k + 1));
    chk("R4 full stack status", 64'(status), 64'h0000);
    chk("R4 full stack tags", 64'(tags), 64'h0000);
    step(4'd2, 3'd0, 64'h99);
    chk("R4 overflow status", 64'(status), 64'h3A41);
    chk("R4 overflow tags", 64'(tags), 64'h0000);
    step(4'd3, 3'd0, 64'h0);
    chk("R4 overwritten value popped", rdata, 64'h99);
    chk("R12 fault bits kept after pop", 64'(status), 64'h0241);
    step(4'd1, 3'd7, 64'h0);
    chk("R7 empty read clears C1", 64'(status), 64'h0041);
    chk("R7 empty read data", rdata, QN);
    step(4'd1, 3'd1, 64'h0);
    chk("R2 depth 1 after wrap", rdata, 64'h7);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset status", 64'(status), 64'h0);
    chk("R1 mid-run reset tags", 64'(tags), 64'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule